// File: doc/BRIEF.md
# Cache Line Fill Sequencer

This block loads one complete cache line from external memory when the cache controller reports a miss. The controller hands over the address of the missing word and the way that will receive the line. The block then starts a read on the memory bus. It marks that read as a line-sized transfer and places the way number on a dedicated pair of pins. It gathers four 32-bit words into a line buffer and signals completion.

Line transfers ask the memory for burst mode. A memory that can burst acknowledges every beat of one held address phase. A memory that cannot burst signals this with the first acknowledge. The sequencer then closes that access and fetches the three remaining words as separate single-word reads, each with its own start strobe and word address. The way number stays on the bus while these reads run. The memory may also flag any beat as non-cacheable, and the sequencer passes that flag to the controller along with the completion pulse.

Top module: `line_fill_seq`

## Requirements
- R1: After reset, and after reset is applied in the middle of a fill, the block is idle: `req_ready` is 1, and `bus_busy`, `bus_ts` and `fill_done` are 0.
- R2: A request is taken only when `req_ready` is 1. A `req_valid` raised during a fill starts no extra bus transfer and does not change the line being filled.
- R3: A fill opens with a one-cycle `bus_ts`. At that point `bus_size` = 2'b11 (line) and `bus_addr` equals the requested address with bits [1:0] cleared. Both stay unchanged for the rest of a burst.
- R4: The word accepted on the k-th acknowledge (k = 0..3) is stored in `line_data` bits [32*o+31:32*o], where o = (requested address bits [3:2] + k) mod 4.
- R5: If `bus_bi` is 1 on the first acknowledge, the block fetches the three remaining words as single reads. Each read has its own one-cycle `bus_ts`, `bus_size` = 2'b00 (long word), and `bus_addr` bits [3:2] equal to the next offset in sequence.
- R6: `bus_bi` is ignored on every acknowledge after the first, so a burst continues to its fourth word with no new `bus_ts`.
- R7: `fill_nc` is 1 alongside `fill_done` when `bus_ci` was 1 on any of the four acknowledges, and 0 otherwise. A new fill clears it.
- R8: `fill_done` is a single-cycle pulse in the cycle after the fourth word is stored. In the next cycle `req_ready` is 1.
- R9: `bus_tln` carries the requested way (00 way 0, 01 way 1, 10 way 2, 11 way 3) throughout every transfer of the fill, including the single reads. `fill_way` reports the same way at completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Line fill request |
| req_addr | input | ADDR_W | Address of the missing word |
| req_way | input | WAY_W | Way to be loaded |
| req_ready | output | 1 | Idle; a request is accepted |
| bus_ts | output | 1 | Transfer start strobe, one cycle per address phase |
| bus_busy | output | 1 | Transfer in progress; address and control valid |
| bus_addr | output | ADDR_W | Transfer address |
| bus_size | output | 2 | 2'b11 line, 2'b00 long word |
| bus_tln | output | WAY_W | Way being loaded |
| bus_ack | input | 1 | Transfer acknowledge, one per word |
| bus_bi | input | 1 | Burst refused (sampled on first acknowledge) |
| bus_ci | input | 1 | Line not cacheable |
| bus_rdata | input | DATA_W | Read data |
| line_data | output | 4*DATA_W | Assembled line, word o at bits [32*o+31:32*o] |
| fill_done | output | 1 | Fill complete pulse |
| fill_nc | output | 1 | Filled line is non-cacheable |
| fill_way | output | WAY_W | Way of the completed fill |

## Verification
Several rules are checked by assertions on every cycle. These are the one-cycle width of the start strobe and of the done pulse, a held address and line size during a burst, a held long-word request during each single read, a steady way number while the bus is busy, and a bus transfer that begins only after an accepted request. Other behaviour shows only in the bench scenarios. Each word must land at its wrapped offset from different start offsets. The fallback must produce exactly three single reads after a refused burst. A late burst refusal and a stray request during a fill must have no effect. The non-cacheable flag must be collected from any beat and cleared again, and a reset in mid-fill must return the block to idle.

// File: rtl/line_fill_seq.sv
module line_fill_seq #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WAY_W  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [WAY_W-1:0]      req_way,
  output logic                  req_ready,
  output logic                  bus_ts,
  output logic                  bus_busy,
  output logic [ADDR_W-1:0]     bus_addr,
  output logic [1:0]            bus_size,
  output logic [WAY_W-1:0]      bus_tln,
  input  logic                  bus_ack,
  input  logic                  bus_bi,
  input  logic                  bus_ci,
  input  logic [DATA_W-1:0]     bus_rdata,
  output logic [4*DATA_W-1:0]   line_data,
  output logic                  fill_done,
  output logic                  fill_nc,
  output logic [WAY_W-1:0]      fill_way
);

  localparam int          WORDS     = 4;
  localparam int          OFS_W     = $clog2(WORDS);
  localparam int          BASE_LSB  = OFS_W + 2;
  localparam logic [1:0]  SZ_LINE   = 2'b11;
  localparam logic [1:0]  SZ_LONG   = 2'b00;
  localparam logic [OFS_W-1:0] LAST = OFS_W'(WORDS - 1);

  typedef enum logic [2:0] {
    IDLE, BURST_FIRST, BURST_REST, SINGLE_ADDR, SINGLE_WAIT, DONE
  } state_t;

  state_t                     state;
  logic [ADDR_W-1:BASE_LSB]   base_q;
  logic [OFS_W-1:0]           start_q, ptr_q, cnt_q;
  logic [WAY_W-1:0]           way_q;
  logic                       nc_q, ts_q;
  logic [WORDS*DATA_W-1:0]    line_q;

  wire in_burst  = (state == BURST_FIRST) || (state == BURST_REST);
  wire in_single = (state == SINGLE_ADDR) || (state == SINGLE_WAIT);
  wire take      = bus_ack && (in_burst || state == SINGLE_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= IDLE;
      base_q  <= '0;
      start_q <= '0;
      ptr_q   <= '0;
      cnt_q   <= '0;
      way_q   <= '0;
      nc_q    <= 1'b0;
      ts_q    <= 1'b0;
      line_q  <= '0;
    end else begin
      ts_q <= 1'b0;
      case (state)
        IDLE: if (req_valid) begin
          base_q  <= req_addr[ADDR_W-1:BASE_LSB];
          start_q <= req_addr[BASE_LSB-1:2];
          ptr_q   <= req_addr[BASE_LSB-1:2];
          way_q   <= req_way;
          cnt_q   <= '0;
          nc_q    <= 1'b0;
          ts_q    <= 1'b1;
          state   <= BURST_FIRST;
        end
        BURST_FIRST: if (bus_ack) state <= bus_bi ? SINGLE_ADDR : BURST_REST;
        BURST_REST:  if (bus_ack && cnt_q == LAST) state <= DONE;
        SINGLE_ADDR: state <= SINGLE_WAIT;
        SINGLE_WAIT: if (bus_ack) state <= (cnt_q == LAST) ? DONE : SINGLE_ADDR;
        DONE:        state <= IDLE;
        default:     state <= IDLE;
      endcase
      if (take) begin
        line_q[ptr_q*DATA_W +: DATA_W] <= bus_rdata;
        ptr_q <= ptr_q + 1'b1;
        cnt_q <= cnt_q + 1'b1;
        nc_q  <= nc_q | bus_ci;
      end
    end
  end

  assign req_ready = (state == IDLE);
  assign bus_busy  = in_burst || in_single;
  assign bus_ts    = ts_q || (state == SINGLE_ADDR);
  assign bus_size  = in_burst ? SZ_LINE : SZ_LONG;
  assign bus_tln   = bus_busy ? way_q : '0;
  assign bus_addr  = in_burst  ? {base_q, start_q, 2'b00} :
                     in_single ? {base_q, ptr_q, 2'b00}   : '0;
  assign line_data = line_q;
  assign fill_done = (state == DONE);
  assign fill_nc   = nc_q;
  assign fill_way  = way_q;

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> (!fill_done && req_ready));

  a_r5_ts_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ts |=> !bus_ts);

  a_r3_burst_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == BURST_REST) |-> ($stable(bus_addr) && bus_size == SZ_LINE));

  a_r5_single_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SINGLE_WAIT) |-> ($stable(bus_addr) && bus_size == SZ_LONG));

  a_r9_way_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && $past(bus_busy)) |-> $stable(bus_tln));

  a_r2_start_on_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_busy) |-> $past(req_valid && req_ready));

endmodule

// File: tb/line_fill_seq_bench.sv
`timescale 1ns/1ps
module line_fill_seq_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic [31:0]  req_addr = '0;
  logic [1:0]   req_way = '0;
  logic         req_ready, bus_ts, bus_busy;
  logic [31:0]  bus_addr;
  logic [1:0]   bus_size, bus_tln;
  logic         bus_ack = 1'b0, bus_bi = 1'b0, bus_ci = 1'b0;
  logic [31:0]  bus_rdata = '0;
  logic [127:0] line_data;
  logic         fill_done, fill_nc;
  logic [1:0]   fill_way;

  int checks = 0;
  int errors = 0;
  int dones  = 0;

  typedef struct { logic [127:0] line; logic nc; logic [1:0] way; } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  line_fill_seq u_line_fill_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_way(req_way), .req_ready(req_ready), .bus_ts(bus_ts), .bus_busy(bus_busy),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_tln(bus_tln), .bus_ack(bus_ack),
    .bus_bi(bus_bi), .bus_ci(bus_ci), .bus_rdata(bus_rdata), .line_data(line_data),
    .fill_done(fill_done), .fill_nc(fill_nc), .fill_way(fill_way));

  function automatic logic [31:0] memw(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Monitor: compares each completed fill against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && fill_done) begin
      exp_t e;
      dones++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected fill_done", 128'd1, 128'd0);
      end else begin
        e = exp_q.pop_front();
        chk(line_data == e.line, "R4 line contents", line_data, e.line);
        chk(fill_nc == e.nc, "R7 non-cacheable flag", 128'(fill_nc), 128'(e.nc));
        chk(fill_way == e.way, "R9 fill_way", 128'(fill_way), 128'(e.way));
      end
    end
  end

  task automatic idle_check(input string req);
    chk(req_ready && !bus_busy && !bus_ts && !fill_done, req,
        128'({req_ready, bus_busy, bus_ts, fill_done}), 128'(4'b1000));
  endtask

  task automatic do_fill(input logic [31:0] addr, input logic [1:0] way,
                         input logic bi_first, input int bi_late, input int ci_beat,
                         input logic poke);
    exp_t e;
    logic [31:0] wa;
    logic [1:0]  st;
    st = addr[3:2];
    for (int o = 0; o < 4; o++)
      e.line[o*32 +: 32] = memw({addr[31:4], 2'(o), 2'b00});
    e.nc  = (ci_beat >= 0 && ci_beat <= 3);
    e.way = way;
    exp_q.push_back(e);
    wa = {addr[31:2], 2'b00};

    @(negedge clk);
    req_valid = 1'b1; req_addr = addr; req_way = way;
    @(negedge clk);
    req_valid = poke; req_addr = addr ^ 32'h0000_1230; req_way = ~way;
    chk(bus_ts == 1'b1, "R3 start strobe", 128'(bus_ts), 128'd1);
    chk(bus_size == 2'b11, "R3 line size", 128'(bus_size), 128'(2'b11));
    chk(bus_addr == wa, "R3 burst address", 128'(bus_addr), 128'(wa));
    chk(bus_tln == way, "R9 line number", 128'(bus_tln), 128'(way));
    chk(req_ready == 1'b0, "R2 not ready while busy", 128'(req_ready), 128'd0);

    @(negedge clk);
    bus_ack = 1'b1; bus_rdata = memw({addr[31:4], st, 2'b00});
    bus_bi = bi_first; bus_ci = (ci_beat == 0);

    if (!bi_first) begin
      for (int k = 1; k < 4; k++) begin
        @(negedge clk);
        chk(bus_ts == 1'b0, "R6 no new start in burst", 128'(bus_ts), 128'd0);
        chk(bus_addr == wa && bus_size == 2'b11, "R3 burst held",
            128'({bus_size, bus_addr}), 128'({2'b11, wa}));
        bus_ack = 1'b1; bus_rdata = memw({addr[31:4], 2'(st + 2'(k)), 2'b00});
        bus_bi = (k == bi_late); bus_ci = (ci_beat == k);
      end
    end else begin
      for (int k = 1; k < 4; k++) begin
        logic [31:0] sa;
        sa = {addr[31:4], 2'(st + 2'(k)), 2'b00};
        @(negedge clk);
        bus_ack = 1'b0; bus_bi = 1'b0; bus_ci = 1'b0;
        chk(bus_ts == 1'b1, "R5 single start strobe", 128'(bus_ts), 128'd1);
        chk(bus_size == 2'b00, "R5 long-word size", 128'(bus_size), 128'd0);
        chk(bus_addr == sa, "R5 single address", 128'(bus_addr), 128'(sa));
        chk(bus_tln == way, "R9 line number in single", 128'(bus_tln), 128'(way));
        @(negedge clk);
        bus_ack = 1'b1; bus_rdata = memw(sa); bus_ci = (ci_beat == k);
      end
    end
    @(negedge clk);
    bus_ack = 1'b0; bus_bi = 1'b0; bus_ci = 1'b0; req_valid = 1'b0;
    chk(fill_done == 1'b1, "R8 done after fourth word", 128'(fill_done), 128'd1);
    @(negedge clk);
    idle_check("R8 ready after done");
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    idle_check("R1 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    idle_check("R1 idle after reset release");

    do_fill(32'h1000_0040, 2'd0, 1'b0, -1, -1, 1'b0);
    do_fill(32'h2000_0A58, 2'd3, 1'b0, -1,  1, 1'b0);
    do_fill(32'h3000_00FC, 2'd1, 1'b0,  2, -1, 1'b1);
    do_fill(32'h4000_0114, 2'd2, 1'b1, -1, -1, 1'b0);
    do_fill(32'h5000_0200, 2'd1, 1'b1, -1,  3, 1'b1);
    do_fill(32'h6000_0338, 2'd2, 1'b0, -1, -1, 1'b0);

    // reset in the middle of a fill
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h7000_0010; req_way = 2'd1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    bus_ack = 1'b1; bus_rdata = 32'hDEAD_BEEF; bus_bi = 1'b1;
    @(negedge clk);
    bus_ack = 1'b0; bus_bi = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    idle_check("R1 idle after mid-fill reset");
    rst_n = 1'b1;
    do_fill(32'h7000_001C, 2'd3, 1'b1, -1, 0, 1'b0);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0 && dones == 7, "R8 every fill completed once",
        128'(dones), 128'd7);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule